// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checks

This block caches mappings from virtual page numbers to physical page numbers. Every entry is compared against the incoming virtual address in parallel. A lookup returns its result combinationally, in the same cycle: a hit or miss indication, the physical address, and a protection-fault flag. The physical address is formed from the stored physical page number and the untranslated page offset. The fault flag comes from checking the entry's permission bits against the access kind and the privilege level of the requester.

When a lookup misses, the requester runs a page-table walk outside this block. It then installs the result through the refill port, and the refill takes effect at the next clock edge. A refill goes to the first of these places that applies:
- an entry that already holds the same page;
- otherwise, the lowest-numbered empty entry;
- otherwise, a victim chosen by a compile-time policy: a rotating FIFO pointer or a free-running LFSR.

A write that hits a clean page raises a one-cycle request, so that the walker can mark the page-table entry dirty. The buffer sets its own copy of the dirty bit at the same edge. A flush input empties the buffer.

Top module: `tlb_fa`

## Requirements
- R1: After reset, and from the cycle a flush is asserted, every entry is invalid. A lookup presented in the same cycle as a flush reports a miss.
- R2: A lookup with `lk_valid`=1 that matches a valid entry raises `lk_hit` in the same cycle. In that cycle `lk_pa` equals the entry's physical page number concatenated above the low `OFF_W` bits of `lk_va`.
- R3: A valid lookup that matches no valid entry gives `lk_miss`=1, `lk_hit`=0, `lk_pa`=0 and `lk_fault`=0. `lk_hit` and `lk_miss` are never both 1.
- R4: On a hit, `lk_fault` is 1 in either of two cases:
  - the access kind is not permitted: reads (`lk_write`=0) need `rf_rd`=1 and writes (`lk_write`=1) need `rf_wr`=1, as installed;
  - `lk_user`=1 and the entry was installed with `rf_usr`=0.
  Kernel accesses (`lk_user`=0) ignore the user bit.
- R5: `lk_dirty_req` is 1 exactly when a write hits an entry whose dirty bit is clear and raises no fault. From the following edge that entry counts as dirty, so a repeated write raises no request.
- R6: A refill that is not flushed writes its page to the first place that applies:
  - the valid entry that already holds the same virtual page, if there is one;
  - otherwise, the lowest-numbered invalid entry;
  - otherwise, the replacement victim.
  No two valid entries ever hold the same page.
- R7: With `REPL`=FIFO, victims are taken in index order 0, 1, 2 … and wrap after `ENTRIES-1`. The pointer advances only on a refill that evicts.
- R8: With `REPL`=LFSR, the victim index is a fold of a free-running, never-zero 16-bit LFSR, and exactly one resident page is displaced per evicting refill.
- R9: A lookup in the same cycle as a refill of the same page sees the contents from before that refill. The new entry is visible from the next cycle.
- R10: A refill presented in the same cycle as a flush installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_user | input | 1 | Privilege: 1 user, 0 kernel |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched nothing; walk needed |
| lk_pa | output | 32 | Translated physical address (0 on miss) |
| lk_fault | output | 1 | Protection violation on a hit |
| lk_dirty_req | output | 1 | Write hit a clean page; mark page table dirty |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_usr | input | 1 | Refill user-accessible flag |
| rf_dirty | input | 1 | Refill dirty flag |

## Verification
Three kinds of internal error surface at the ports within one cycle of the next lookup:
- A corrupt valid bit or tag shows up as a wrong hit or miss.
- A wrong physical page shows up in `lk_pa`.
- A wrong permission or dirty bit changes `lk_fault` or `lk_dirty_req`.

A wrong replacement choice stays hidden until the evicted or the surviving page is looked up again. So the FIFO and LFSR scenarios fill the buffer completely, force an eviction, and then probe every resident page. A dirty bit that fails to stick appears only on the second write to the same page, so those writes run back to back.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Permission and state bits stored with every entry
    typedef struct packed {
        logic rd;
        logic wr;
        logic usr;
        logic dirty;
    } tlb_perm_t;

    // Victim selection policy once no entry is free
    typedef enum logic {
        REPL_FIFO = 1'b0,
        REPL_LFSR = 1'b1
    } tlb_repl_e;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Fault when the access kind is not permitted or a user touches a kernel page
    function automatic logic perm_fault(input tlb_perm_t p, input logic is_wr, input logic is_usr);
        logic kind_bad;
        kind_bad = is_wr ? !p.wr : !p.rd;
        return kind_bad || (is_usr && !p.usr);
    endfunction

    // Maximal-length Fibonacci LFSR, taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  tlb_perm_t          wr_perm,
    input  logic               dset_en,
    input  logic [IDX_W-1:0]   dset_idx,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] rf_match,
    output logic [PPN_W-1:0]   hit_ppn,
    output tlb_perm_t          hit_perm,
    output logic [IDX_W-1:0]   hit_idx
);

    logic [PPN_W-1:0] ppn_gated  [ENTRIES];
    tlb_perm_t        perm_gated [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic             vld_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PPN_W-1:0] ppn_q;
        tlb_perm_t        perm_q;

        // Flush beats refill, refill beats the dirty-bit set
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                vpn_q  <= '0;
                ppn_q  <= '0;
                perm_q <= '0;
            end else if (flush) begin
                vld_q <= 1'b0;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                vld_q  <= 1'b1;
                vpn_q  <= rf_vpn;
                ppn_q  <= wr_ppn;
                perm_q <= wr_perm;
            end else if (dset_en && (dset_idx == MY_IDX)) begin
                perm_q.dirty <= 1'b1;
            end
        end

        assign valid_vec[g]  = vld_q;
        assign lk_match[g]   = vld_q && (vpn_q == lk_vpn);
        assign rf_match[g]   = vld_q && (vpn_q == rf_vpn);
        assign ppn_gated[g]  = lk_match[g] ? ppn_q  : '0;
        assign perm_gated[g] = lk_match[g] ? perm_q : '0;
    end

    // One-hot match reduced by OR: no priority chain
    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        hit_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppn  = hit_ppn | ppn_gated[i];
            hit_perm = tlb_perm_t'(hit_perm | perm_gated[i]);
            if (lk_match[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));                                   // R1
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));                                            // R6
    AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_vec[$past(wr_idx)]);                // R6

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int        ENTRIES = 32,
    parameter tlb_repl_e REPL    = REPL_FIFO,
    localparam int       IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim_idx
);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] repl_idx;
    logic             evict;

    // Lowest-numbered empty entry wins (scan downward, last write wins)
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign evict = alloc && !any_free;

    if (REPL == REPL_FIFO) begin : g_fifo
        logic [IDX_W-1:0] ptr_q;

        always_ff @(posedge clk) begin
            if (rst)        ptr_q <= '0;
            else if (evict) ptr_q <= ptr_q + 1'b1;
        end

        assign repl_idx = ptr_q;

        AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
            !evict |=> $stable(ptr_q));                                 // R7
        AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
            evict |=> (ptr_q == IDX_W'($past(ptr_q) + 1'b1)));          // R7
    end else begin : g_lfsr
        logic [LFSR_W-1:0] lfsr_q;

        always_ff @(posedge clk) begin
            if (rst) lfsr_q <= LFSR_SEED;
            else     lfsr_q <= lfsr_step(lfsr_q);
        end

        // Fold every state bit into the index
        always_comb begin
            repl_idx = '0;
            for (int b = 0; b < LFSR_W; b++) begin
                repl_idx[b % IDX_W] = repl_idx[b % IDX_W] ^ lfsr_q[b];
            end
        end

        AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
            lfsr_q != '0);                                              // R8
    end

    assign victim_idx = any_free ? free_idx : repl_idx;

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (alloc && any_free) |-> !valid_vec[victim_idx]);                // R6

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int        ENTRIES = 32,
    parameter int        VA_W    = 32,
    parameter int        PA_W    = 32,
    parameter int        OFF_W   = 12,
    parameter tlb_repl_e REPL    = REPL_FIFO,
    localparam int       VPN_W   = VA_W - OFF_W,
    localparam int       PPN_W   = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_fault,
    output logic             lk_dirty_req,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_rd,
    input  logic             rf_wr,
    input  logic             rf_usr,
    input  logic             rf_dirty
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] rf_match;
    logic [PPN_W-1:0]   hit_ppn;
    tlb_perm_t          hit_perm;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   rf_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               rf_go;
    logic               rf_same;
    logic               alloc;
    logic               hit_any;
    tlb_perm_t          wr_perm;

    // ---------------- lookup path ----------------
    assign hit_any      = lk_valid && !flush && (|lk_match);
    assign lk_hit       = hit_any;
    assign lk_miss      = lk_valid && !hit_any;
    assign lk_fault     = hit_any && perm_fault(hit_perm, lk_write, lk_user);
    assign lk_dirty_req = hit_any && lk_write && !lk_fault && !hit_perm.dirty;
    assign lk_pa        = hit_any ? {hit_ppn, lk_va[OFF_W-1:0]} : '0;

    // ---------------- refill path ----------------
    always_comb begin
        rf_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rf_match[i]) rf_idx = rf_idx | IDX_W'(i);
        end
    end

    assign rf_go   = rf_valid && !flush;
    assign rf_same = |rf_match;
    assign alloc   = rf_go && !rf_same;
    assign wr_idx  = rf_same ? rf_idx : victim_idx;
    assign wr_perm = '{rd: rf_rd, wr: rf_wr, usr: rf_usr, dirty: rf_dirty};

    tlb_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_vpn    (lk_va[VA_W-1:OFF_W]),
        .rf_vpn    (rf_vpn),
        .wr_en     (rf_go),
        .wr_idx    (wr_idx),
        .wr_ppn    (rf_ppn),
        .wr_perm   (wr_perm),
        .dset_en   (lk_dirty_req),
        .dset_idx  (hit_idx),
        .valid_vec (valid_vec),
        .lk_match  (lk_match),
        .rf_match  (rf_match),
        .hit_ppn   (hit_ppn),
        .hit_perm  (hit_perm),
        .hit_idx   (hit_idx)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .REPL    (REPL)
    ) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .alloc      (alloc),
        .victim_idx (victim_idx)
    );

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));                                          // R3
    AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_fault && lk_pa == '0));                        // R4
    AST_DIRTY_QUAL: assert property (@(posedge clk) disable iff (rst)
        lk_dirty_req |-> (lk_hit && lk_write && !lk_fault));            // R5
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        flush |-> !lk_hit);                                             // R1

endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    import tlb_pkg::*;

    localparam int N = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst, flush, lk_valid, lk_write, lk_user;
    logic [31:0] lk_va;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty_req;
    logic [31:0] lk_pa;
    logic        rf_valid, rf_rd, rf_wr, rf_usr, rf_dirty;
    logic [19:0] rf_vpn, rf_ppn;

    logic        r_lk_valid, r_rf_valid;
    logic [31:0] r_lk_va, r_pa;
    logic [19:0] r_rf_vpn, r_rf_ppn;
    logic        r_hit, r_miss, r_fault, r_dreq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    tlb_fa #(.ENTRIES(N), .REPL(REPL_FIFO)) u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_fault(lk_fault),
        .lk_dirty_req(lk_dirty_req),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_usr(rf_usr), .rf_dirty(rf_dirty)
    );

    tlb_fa #(.ENTRIES(N), .REPL(REPL_LFSR)) u_rnd (
        .clk(clk), .rst(rst), .flush(1'b0),
        .lk_valid(r_lk_valid), .lk_va(r_lk_va), .lk_write(1'b0), .lk_user(1'b0),
        .lk_hit(r_hit), .lk_miss(r_miss), .lk_pa(r_pa), .lk_fault(r_fault),
        .lk_dirty_req(r_dreq),
        .rf_valid(r_rf_valid), .rf_vpn(r_rf_vpn), .rf_ppn(r_rf_ppn),
        .rf_rd(1'b1), .rf_wr(1'b1), .rf_usr(1'b1), .rf_dirty(1'b1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_refill(input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic r, input logic w, input logic u, input logic d);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
        rf_rd = r; rf_wr = w; rf_usr = u; rf_dirty = d;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] va, input logic wr, input logic usr);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_write = wr; lk_user = usr;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; lk_user = 1'b0;
    endtask

    task automatic t_reset();
        probe(32'h1234_5000, 1'b0, 1'b0);
        chk("R1 reset empty: hit", lk_hit, 0);
        chk("R3 reset miss", lk_miss, 1);
        chk("R3 miss pa zero", lk_pa, 0);
        chk("R3 miss no fault", lk_fault, 0);
        idle();
    endtask

    task automatic t_hit();
        do_refill(20'h12345, 20'hABCDE, 1, 1, 1, 0);
        probe(32'h1234_5678, 1'b0, 1'b1);
        chk("R2 hit", lk_hit, 1);
        chk("R2 pa concat", lk_pa, 32'hABCD_E678);
        probe(32'h1234_6000, 1'b0, 1'b0);
        chk("R3 other page misses", lk_miss, 1);
        idle();
    endtask

    task automatic t_perm();
        do_refill(20'h00010, 20'h00200, 1, 0, 0, 1);
        probe(32'h0001_0004, 1'b1, 1'b0);
        chk("R4 write to read-only faults", lk_fault, 1);
        probe(32'h0001_0004, 1'b0, 1'b1);
        chk("R4 user on kernel page faults", lk_fault, 1);
        probe(32'h0001_0004, 1'b0, 1'b0);
        chk("R4 kernel read ok (hit)", lk_hit, 1);
        chk("R4 kernel read ok (fault)", lk_fault, 0);
        do_refill(20'h00011, 20'h00300, 0, 1, 1, 1);
        probe(32'h0001_1000, 1'b0, 1'b1);
        chk("R4 read without rd faults", lk_fault, 1);
        probe(32'h0001_1000, 1'b1, 1'b1);
        chk("R4 user write permitted", lk_fault, 0);
        idle();
    endtask

    task automatic t_dirty();
        probe(32'h1234_5010, 1'b1, 1'b1);
        chk("R5 first write to clean page requests", lk_dirty_req, 1);
        probe(32'h1234_5020, 1'b1, 1'b1);
        chk("R5 second write no request", lk_dirty_req, 0);
        chk("R5 second write still hits", lk_hit, 1);
        do_refill(20'h00020, 20'h00400, 1, 0, 1, 0);
        probe(32'h0002_0000, 1'b1, 1'b1);
        chk("R5 faulting write no request", lk_dirty_req, 0);
        do_refill(20'h00021, 20'h00401, 1, 1, 1, 0);
        probe(32'h0002_1000, 1'b0, 1'b1);
        chk("R5 read of clean page no request", lk_dirty_req, 0);
        idle();
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = 20'h00030; rf_ppn = 20'h00500;
        rf_rd = 1; rf_wr = 1; rf_usr = 1; rf_dirty = 1;
        lk_valid = 1'b1; lk_va = 32'h0003_0123; lk_write = 1'b0; lk_user = 1'b0;
        #2;
        chk("R9 lookup sees old contents", lk_hit, 0);
        @(negedge clk);
        rf_valid = 1'b0;
        #2;
        chk("R9 refill visible next cycle", lk_pa, 32'h0050_0123);
        idle();
    endtask

    task automatic t_overwrite();
        do_refill(20'h12345, 20'h11111, 1, 1, 1, 1);
        probe(32'h1234_5678, 1'b0, 1'b0);
        chk("R6 same page overwritten", lk_pa, 32'h1111_1678);
        idle();
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        lk_valid = 1'b1; lk_va = 32'h1234_5678; lk_write = 1'b0; lk_user = 1'b0;
        #2;
        chk("R1 lookup during flush misses", lk_miss, 1);
        @(negedge clk);
        flush = 1'b0;
        #2;
        chk("R1 entry gone after flush", lk_hit, 0);
        idle();
    endtask

    task automatic t_flush_refill();
        @(negedge clk);
        flush = 1'b1;
        rf_valid = 1'b1; rf_vpn = 20'h00040; rf_ppn = 20'h00600;
        @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0;
        probe(32'h0004_0000, 1'b0, 1'b0);
        chk("R10 refill during flush dropped", lk_hit, 0);
        idle();
    endtask

    task automatic t_fifo();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < N; i++) do_refill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 1);
        probe(32'h0011_F000, 1'b0, 1'b0);
        chk("R6 last free entry filled", lk_pa, 32'h0021_F000);
        do_refill(20'h00300, 20'h00700, 1, 1, 1, 1);
        probe(32'h0010_0000, 1'b0, 1'b0);
        chk("R7 oldest evicted first", lk_hit, 0);
        probe(32'h0010_1000, 1'b0, 1'b0);
        chk("R7 second oldest survives", lk_hit, 1);
        probe(32'h0030_0000, 1'b0, 1'b0);
        chk("R7 new page resident", lk_pa, 32'h0070_0000);
        do_refill(20'h00301, 20'h00701, 1, 1, 1, 1);
        probe(32'h0010_1000, 1'b0, 1'b0);
        chk("R7 pointer advanced to index 1", lk_hit, 0);
        probe(32'h0010_2000, 1'b0, 1'b0);
        chk("R7 index 2 survives", lk_hit, 1);
        idle();
    endtask

    task automatic t_random();
        int cnt;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            r_rf_valid = 1'b1; r_rf_vpn = 20'h00500 + 20'(i); r_rf_ppn = 20'h00800 + 20'(i);
        end
        @(negedge clk);
        r_rf_vpn = 20'h00600; r_rf_ppn = 20'h00900;
        @(negedge clk);
        r_rf_valid = 1'b0;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            r_lk_valid = 1'b1; r_lk_va = {20'h00500 + 20'(i), 12'h000};
            #2;
            if (r_hit) cnt++;
        end
        chk("R8 exactly one page displaced", 64'(cnt), 64'(N - 1));
        @(negedge clk);
        r_lk_va = 32'h0060_0abc;
        #2;
        chk("R8 new page resident", r_pa, 32'h0090_0abc);
        @(negedge clk);
        r_lk_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_write = 1'b0; lk_user = 1'b0;
        rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_rd = 1'b0; rf_wr = 1'b0; rf_usr = 1'b0; rf_dirty = 1'b0;
        r_lk_valid = 1'b0; r_lk_va = '0; r_rf_valid = 1'b0; r_rf_vpn = '0; r_rf_ppn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hit();
        t_perm();
        t_dirty();
        t_same_cycle();
        t_overwrite();
        t_flush();
        t_flush_refill();
        t_fifo();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule